// File: doc/BRIEF.md
# Dictionary Code Decompression Stage

This stage sits between instruction fetch and decode in a core whose instructions are 16 or 32 bits long. The code image it reads is compressed item by item: each slot holds either a one-byte dictionary index or an untouched raw instruction. Every slot has one marker bit. The marker bits are packed into bytes in their own memory region, so the code bytes stay byte-aligned. For an index slot the stage reads a 256-entry dictionary. The length of that entry follows from where the index falls relative to a programmable split point, because all short entries sit below the split and all long ones at or above it. For a raw slot the stage passes the bytes through and takes the length from the instruction's own low bit. Each emitted item carries the instruction's address in the uncompressed program.

The stage starts and restarts only on a redirect. The original target address is searched in a 16-entry translation table. A hit gives the compressed code address, the byte address of the marker bit and its position inside that byte. All pointers are reloaded from that hit and the stream resumes from the target item. Because no item spans more than one instruction, any instruction can be a target. A miss raises a fault and parks the stage. The dictionary, the split point and the table are filled through write ports while the stage is idle. The code and marker memories are read through address and data ports that return data combinationally.

Top module: `dcmp_stage`

## Requirements
- R1: After reset, outValid and fault are 0 and stay 0 until a redirect arrives.
- R2: A slot whose marker bit is 1 holds one index byte (the byte at codeAddr). The stage emits the dictionary word written at that index through the load port, and the code pointer moves forward by 1 byte when the item is accepted.
- R3: An index below the split value is a 16-bit entry: outIs32=0 and outInstr holds the low 16 bits of the word, with the upper 16 bits forced to 0. An index equal to or above the split value is a 32-bit entry: outIs32=1 and outInstr holds the full word.
- R4: A slot whose marker bit is 0 is a raw instruction stored little-endian at codeAddr. If bit 0 of its first byte is 1, the stage emits 4 bytes with outIs32=1 and the code pointer moves forward by 4. Otherwise it emits 2 bytes with the upper 16 bits 0, and the code pointer moves forward by 2.
- R5: Marker bits are used least significant bit first, one bit per accepted item. After the item at bit position 7 is accepted, the marker address increments and the next cycle has outValid=0 while the new marker byte is loaded.
- R6: outPc begins at the redirect address and grows by 4 after each accepted 32-bit item and by 2 after each accepted 16-bit item.
- R7: A redirect that hits the table makes the next cycle a load cycle with outValid=0. From the cycle after that, the target item is presented. A redirect overrides a handshake in the same cycle, so the item shown in that cycle is dropped.
- R8: A redirect whose address matches no written table entry sets fault in the next cycle and keeps outValid at 0 until a redirect that hits, which clears fault.
- R9: While outValid is 1 and outReady is 0, with no redirect, outValid, outInstr, outIs32 and outPc hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| dictWrEn | input | 1 | Dictionary write strobe |
| dictWrIdx | input | 8 | Dictionary entry being written |
| dictWrData | input | 32 | Dictionary word |
| bndWrEn | input | 1 | Split value write strobe |
| bndWrData | input | 8 | First index of the 32-bit entries |
| batWrEn | input | 1 | Translation table write strobe |
| batWrIdx | input | 4 | Table entry being written |
| batWrOrig | input | 16 | Original target address of the entry |
| batWrCode | input | 16 | Compressed code address of the entry |
| batWrFlagAddr | input | 16 | Marker byte address of the entry |
| batWrFlagBit | input | 3 | Marker bit position of the entry |
| redirValid | input | 1 | Redirect request |
| redirAddr | input | 16 | Original address of the redirect target |
| codeAddr | output | 16 | Compressed code read address |
| codeWin | input | 32 | Four code bytes starting at codeAddr, lowest address in bits 7:0 |
| flagAddr | output | 16 | Marker byte read address |
| flagData | input | 8 | Marker byte at flagAddr |
| outValid | output | 1 | Emitted item valid |
| outReady | input | 1 | Decode accepts the item |
| outInstr | output | 32 | Expanded instruction |
| outIs32 | output | 1 | 1 for a 32-bit instruction |
| outPc | output | 16 | Original program address of the item |
| fault | output | 1 | Last redirect missed the table |

## Verification
The interesting overlap is a redirect that arrives in the same cycle as an accepted handshake. The bench redirects while item 18 is shown with outReady high, then checks that a load bubble follows and that the next item presented is the target, not item 19. A second overlap is a marker byte rollover against the stall handshake. Ready is withheld in a fixed rhythm over a sweep of every dictionary index plus a mixed raw and index prefix. The bench checks each presented item against a stream it builds itself, and checks for a bubble after every eighth accepted item.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
  localparam int INSTR_W = 32;
  localparam int HALF_W = 16;
  localparam int IDX_W = 8;
  localparam int DICT_DEPTH = 1 << IDX_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_FAULT
  } stage_e;

  typedef struct packed {
    logic takeRedir;
    logic latchFlag;
    logic advance;
  } strobe_t;
endpackage

// File: rtl/dcmp_ctrl.sv
module dcmp_ctrl
  import dcmp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    redirValid,
  input  logic    batHit,
  input  logic    lastBit,
  input  logic    outReady,
  output strobe_t strobes,
  output logic    outValid,
  output logic    fault
);
  stage_e state, stateNext;

  always_comb begin
    strobes.takeRedir = redirValid && batHit;
    strobes.latchFlag = (state == ST_LOAD) && !redirValid;
    strobes.advance   = (state == ST_RUN) && outReady && !redirValid;
  end

  assign outValid = (state == ST_RUN);
  assign fault    = (state == ST_FAULT);

  always_comb begin
    stateNext = state;
    if (redirValid) begin
      stateNext = batHit ? ST_LOAD : ST_FAULT;
    end else begin
      unique case (state)
        ST_LOAD: stateNext = ST_RUN;
        ST_RUN:  if (strobes.advance && lastBit) stateNext = ST_LOAD;
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_HIT_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (redirValid && batHit) |=> (!outValid && !fault)); // R7
  AST_MISS_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (redirValid && !batHit) |=> (fault && !outValid)); // R8
  AST_ROLL_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && lastBit) |=> !outValid); // R5
endmodule

// File: rtl/dcmp_datapath.sv
module dcmp_datapath
  import dcmp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BAT_DEPTH = 16,
  localparam int BAT_IDX_W = $clog2(BAT_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic                 dictWrEn,
  input  logic [IDX_W-1:0]     dictWrIdx,
  input  logic [INSTR_W-1:0]   dictWrData,
  input  logic                 bndWrEn,
  input  logic [IDX_W-1:0]     bndWrData,
  input  logic                 batWrEn,
  input  logic [BAT_IDX_W-1:0] batWrIdx,
  input  logic [ADDR_W-1:0]    batWrOrig,
  input  logic [ADDR_W-1:0]    batWrCode,
  input  logic [ADDR_W-1:0]    batWrFlagAddr,
  input  logic [2:0]           batWrFlagBit,
  input  logic [ADDR_W-1:0]    redirAddr,
  input  logic [INSTR_W-1:0]   codeWin,
  input  logic [7:0]           flagData,
  output logic [ADDR_W-1:0]    codeAddr,
  output logic [ADDR_W-1:0]    flagAddr,
  output logic [INSTR_W-1:0]   outInstr,
  output logic                 outIs32,
  output logic [ADDR_W-1:0]    outPc,
  output logic                 batHit,
  output logic                 lastBit
);
  logic [INSTR_W-1:0] dictMem [DICT_DEPTH];
  logic [IDX_W-1:0]   bndReg;

  logic [ADDR_W-1:0]  batOrig [BAT_DEPTH];
  logic [ADDR_W-1:0]  batCode [BAT_DEPTH];
  logic [ADDR_W-1:0]  batFlag [BAT_DEPTH];
  logic [2:0]         batBit  [BAT_DEPTH];
  logic [BAT_DEPTH-1:0] batValid;
  logic [BAT_DEPTH-1:0] matchVec;

  logic [ADDR_W-1:0] codePtr, flagPtr, origPc;
  logic [2:0]        bitPos;
  logic [7:0]        flagReg;

  logic [ADDR_W-1:0] hitCode, hitFlag;
  logic [2:0]        hitBit;

  // dictionary and split value
  always_ff @(posedge clk) begin
    if (dictWrEn) dictMem[dictWrIdx] <= dictWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        bndReg <= '0;
    else if (bndWrEn) bndReg <= bndWrData;
  end

  // translation table
  always_ff @(posedge clk) begin
    if (batWrEn) begin
      batOrig[batWrIdx] <= batWrOrig;
      batCode[batWrIdx] <= batWrCode;
      batFlag[batWrIdx] <= batWrFlagAddr;
      batBit[batWrIdx]  <= batWrFlagBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        batValid <= '0;
    else if (batWrEn) batValid[batWrIdx] <= 1'b1;
  end

  for (genvar g = 0; g < BAT_DEPTH; g++) begin : g_match
    assign matchVec[g] = batValid[g] && (batOrig[g] == redirAddr);
  end

  always_comb begin
    hitCode = '0;
    hitFlag = '0;
    hitBit  = '0;
    for (int i = BAT_DEPTH - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hitCode = batCode[i];
        hitFlag = batFlag[i];
        hitBit  = batBit[i];
      end
    end
  end
  assign batHit = |matchVec;

  // item formation
  logic               isIdx, dictIs32, rawIs32;
  logic [IDX_W-1:0]   idx;
  logic [INSTR_W-1:0] dictWord;
  logic [2:0]         codeStep;

  assign isIdx    = flagReg[bitPos];
  assign idx      = codeWin[IDX_W-1:0];
  assign dictWord = dictMem[idx];
  assign dictIs32 = (idx >= bndReg);
  assign rawIs32  = codeWin[0];

  always_comb begin
    if (isIdx) begin
      outIs32  = dictIs32;
      outInstr = dictIs32 ? dictWord : {{HALF_W{1'b0}}, dictWord[HALF_W-1:0]};
      codeStep = 3'd1;
    end else begin
      outIs32  = rawIs32;
      outInstr = rawIs32 ? codeWin : {{HALF_W{1'b0}}, codeWin[HALF_W-1:0]};
      codeStep = rawIs32 ? 3'd4 : 3'd2;
    end
  end

  assign codeAddr = codePtr;
  assign flagAddr = flagPtr;
  assign outPc    = origPc;
  assign lastBit  = (bitPos == 3'd7);

  // pointers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codePtr <= '0;
      flagPtr <= '0;
      origPc  <= '0;
      bitPos  <= '0;
      flagReg <= '0;
    end else if (strobes.takeRedir) begin
      codePtr <= hitCode;
      flagPtr <= hitFlag;
      bitPos  <= hitBit;
      origPc  <= redirAddr;
    end else if (strobes.latchFlag) begin
      flagReg <= flagData;
    end else if (strobes.advance) begin
      codePtr <= codePtr + ADDR_W'(codeStep);
      origPc  <= origPc + (outIs32 ? ADDR_W'(4) : ADDR_W'(2));
      bitPos  <= bitPos + 3'd1;
      if (lastBit) flagPtr <= flagPtr + ADDR_W'(1);
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> (outPc == $past(outPc) + ($past(outIs32) ? ADDR_W'(4) : ADDR_W'(2)))); // R6
  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> ((codeAddr - $past(codeAddr)) inside {ADDR_W'(1), ADDR_W'(2), ADDR_W'(4)})); // R4
  AST_FLAG_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && lastBit) |=> (flagAddr == $past(flagAddr) + ADDR_W'(1))); // R5
endmodule

// File: rtl/dcmp_stage.sv
module dcmp_stage
  import dcmp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BAT_DEPTH = 16,
  localparam int BAT_IDX_W = $clog2(BAT_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dictWrEn,
  input  logic [7:0]           dictWrIdx,
  input  logic [31:0]          dictWrData,
  input  logic                 bndWrEn,
  input  logic [7:0]           bndWrData,
  input  logic                 batWrEn,
  input  logic [BAT_IDX_W-1:0] batWrIdx,
  input  logic [ADDR_W-1:0]    batWrOrig,
  input  logic [ADDR_W-1:0]    batWrCode,
  input  logic [ADDR_W-1:0]    batWrFlagAddr,
  input  logic [2:0]           batWrFlagBit,
  input  logic                 redirValid,
  input  logic [ADDR_W-1:0]    redirAddr,
  output logic [ADDR_W-1:0]    codeAddr,
  input  logic [31:0]          codeWin,
  output logic [ADDR_W-1:0]    flagAddr,
  input  logic [7:0]           flagData,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [31:0]          outInstr,
  output logic                 outIs32,
  output logic [ADDR_W-1:0]    outPc,
  output logic                 fault
);
  strobe_t strobes;
  logic    batHit;
  logic    lastBit;

  dcmp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .redirValid (redirValid),
    .batHit     (batHit),
    .lastBit    (lastBit),
    .outReady   (outReady),
    .strobes    (strobes),
    .outValid   (outValid),
    .fault      (fault)
  );

  dcmp_datapath #(
    .ADDR_W    (ADDR_W),
    .BAT_DEPTH (BAT_DEPTH)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .dictWrEn      (dictWrEn),
    .dictWrIdx     (dictWrIdx),
    .dictWrData    (dictWrData),
    .bndWrEn       (bndWrEn),
    .bndWrData     (bndWrData),
    .batWrEn       (batWrEn),
    .batWrIdx      (batWrIdx),
    .batWrOrig     (batWrOrig),
    .batWrCode     (batWrCode),
    .batWrFlagAddr (batWrFlagAddr),
    .batWrFlagBit  (batWrFlagBit),
    .redirAddr     (redirAddr),
    .codeWin       (codeWin),
    .flagData      (flagData),
    .codeAddr      (codeAddr),
    .flagAddr      (flagAddr),
    .outInstr      (outInstr),
    .outIs32       (outIs32),
    .outPc         (outPc),
    .batHit        (batHit),
    .lastBit       (lastBit)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !redirValid) |=>
      (outValid && $stable(outInstr) && $stable(outIs32) && $stable(outPc))); // R9
  AST_SHORT_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outIs32) |-> (outInstr[31:16] == 16'h0)); // R3
endmodule

// File: tb/dcmp_stage_test.sv
module dcmp_stage_test;
  localparam int NMIX = 40;
  localparam int NI = NMIX + 256;
  localparam int SPLIT = 100;
  localparam logic [15:0] ORG = 16'h1000;
  localparam logic [15:0] FBASE = 16'h0200;

  logic        clk = 0;
  logic        rstN = 0;
  logic        dictWrEn = 0;
  logic [7:0]  dictWrIdx = 0;
  logic [31:0] dictWrData = 0;
  logic        bndWrEn = 0;
  logic [7:0]  bndWrData = 0;
  logic        batWrEn = 0;
  logic [3:0]  batWrIdx = 0;
  logic [15:0] batWrOrig = 0, batWrCode = 0, batWrFlagAddr = 0;
  logic [2:0]  batWrFlagBit = 0;
  logic        redirValid = 0;
  logic [15:0] redirAddr = 0;
  logic [15:0] codeAddr, flagAddr, outPc;
  logic [31:0] codeWin, outInstr;
  logic [7:0]  flagData;
  logic        outValid, outIs32, fault;
  logic        outReady = 0;

  logic [7:0]  codeMem [512];
  logic [7:0]  flagMem [64];
  logic [31:0] expInstr [NI];
  logic        expIs32 [NI];
  logic        expIdx [NI];
  logic [15:0] expPc [NI];
  logic [15:0] expCode [NI];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign codeWin = {codeMem[(int'(codeAddr) + 3) % 512], codeMem[(int'(codeAddr) + 2) % 512],
                    codeMem[(int'(codeAddr) + 1) % 512], codeMem[int'(codeAddr) % 512]};
  assign flagData = flagMem[(int'(flagAddr) - int'(FBASE)) & 63];

  dcmp_stage uut (
    .clk(clk), .rstN(rstN),
    .dictWrEn(dictWrEn), .dictWrIdx(dictWrIdx), .dictWrData(dictWrData),
    .bndWrEn(bndWrEn), .bndWrData(bndWrData),
    .batWrEn(batWrEn), .batWrIdx(batWrIdx), .batWrOrig(batWrOrig), .batWrCode(batWrCode),
    .batWrFlagAddr(batWrFlagAddr), .batWrFlagBit(batWrFlagBit),
    .redirValid(redirValid), .redirAddr(redirAddr),
    .codeAddr(codeAddr), .codeWin(codeWin), .flagAddr(flagAddr), .flagData(flagData),
    .outValid(outValid), .outReady(outReady), .outInstr(outInstr), .outIs32(outIs32),
    .outPc(outPc), .fault(fault)
  );

  function automatic logic [31:0] dictVal(int i);
    if (i < SPLIT) return {8'hEE, 8'(i), 8'(i) ^ 8'h5A, 8'(i)};
    return {8'(i), ~8'(i), 8'(i + 3), 8'(i) ^ 8'hC3};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic buildImage();
    int ca = 0;
    logic [15:0] pc = ORG;
    for (int i = 0; i < 512; i++) codeMem[i] = 8'h00;
    for (int i = 0; i < 64; i++) flagMem[i] = 8'h00;
    for (int k = 0; k < NI; k++) begin
      int kind = (k < NMIX) ? (k % 3) : 0;
      expCode[k] = 16'(ca);
      expPc[k] = pc;
      expIdx[k] = (kind == 0);
      if (kind == 0) begin
        int idx = (k < NMIX) ? ((k * 37 + 11) % 256) : (k - NMIX);
        if (k == 3) idx = SPLIT - 1;
        if (k == 6) idx = SPLIT;
        flagMem[k / 8][k % 8] = 1'b1;
        codeMem[ca] = 8'(idx);
        ca += 1;
        expIs32[k] = (idx >= SPLIT);
        expInstr[k] = expIs32[k] ? dictVal(idx) : {16'h0, dictVal(idx)[15:0]};
      end else if (kind == 1) begin
        logic [7:0] b0 = {7'(k), 1'b0};
        logic [7:0] b1 = 8'(k) ^ 8'h33;
        codeMem[ca] = b0; codeMem[ca + 1] = b1;
        ca += 2;
        expIs32[k] = 1'b0;
        expInstr[k] = {16'h0, b1, b0};
      end else begin
        logic [7:0] b0 = {7'(k), 1'b1};
        logic [7:0] b1 = 8'(k + 1);
        logic [7:0] b2 = 8'(k * 3);
        codeMem[ca] = b0; codeMem[ca + 1] = b1; codeMem[ca + 2] = b2; codeMem[ca + 3] = 8'hA5;
        ca += 4;
        expIs32[k] = 1'b1;
        expInstr[k] = {8'hA5, b2, b1, b0};
      end
      pc += expIs32[k] ? 16'd4 : 16'd2;
    end
  endtask

  task automatic loadTables();
    int tgt[5] = '{0, 13, 22, 30, 40};
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      dictWrEn = 1; dictWrIdx = 8'(i); dictWrData = dictVal(i);
    end
    @(negedge clk);
    dictWrEn = 0; bndWrEn = 1; bndWrData = 8'(SPLIT);
    for (int e = 0; e < 5; e++) begin
      @(negedge clk);
      bndWrEn = 0;
      batWrEn = 1; batWrIdx = 4'(e);
      batWrOrig = expPc[tgt[e]];
      batWrCode = expCode[tgt[e]];
      batWrFlagAddr = FBASE + 16'(tgt[e] / 8);
      batWrFlagBit = 3'(tgt[e] % 8);
    end
    @(negedge clk);
    batWrEn = 0;
  endtask

  task automatic redirect(logic [15:0] a, bit rdy);
    @(negedge clk);
    redirValid = 1; redirAddr = a; outReady = rdy;
    @(negedge clk);
    redirValid = 0; outReady = 0;
    #1;
  endtask

  task automatic consume(int first, int count);
    int k = first;
    int got = 0;
    int cyc = 0;
    bit bubbleDue = 0;
    while (got < count) begin
      @(negedge clk);
      outReady = ((cyc % 5) != 2);
      cyc++;
      #1;
      if (bubbleDue) begin
        check(!outValid, "R5 bubble after marker byte end", 32'(outValid), 32'd0);
        bubbleDue = 0;
      end else if (outValid) begin
        if (!outReady)
          check(outInstr == expInstr[k] && outIs32 == expIs32[k], "R9 stall hold", outInstr, expInstr[k]);
        else if (expIdx[k])
          check(outInstr == expInstr[k] && outIs32 == expIs32[k], "R2/R3 dictionary item", outInstr, expInstr[k]);
        else
          check(outInstr == expInstr[k] && outIs32 == expIs32[k], "R4 raw item", outInstr, expInstr[k]);
        check(outPc == expPc[k], "R6 original pc", 32'(outPc), 32'(expPc[k]));
        if (outReady) begin
          got++;
          if (k % 8 == 7) bubbleDue = 1;
          k++;
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    buildImage();
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    check(!outValid && !fault, "R1 reset state", {30'd0, outValid, fault}, 32'd0);
    loadTables();
    #1;
    check(!outValid && !fault, "R1 idle before redirect", {30'd0, outValid, fault}, 32'd0);

    // full sweep: mixed prefix then every dictionary index
    redirect(expPc[0], 0);
    check(!outValid && !fault, "R7 load cycle after hit", {30'd0, outValid, fault}, 32'd0);
    @(negedge clk); #1;
    check(outValid, "R7 target shown two cycles after redirect", 32'(outValid), 32'd1);
    consume(0, NI);

    // mid-byte target, then redirect colliding with a handshake
    redirect(expPc[13], 0);
    consume(13, 5);
    redirect(expPc[22], 1);
    check(!outValid, "R7 redirect wins over handshake", 32'(outValid), 32'd0);
    consume(22, 10);

    // misses
    redirect(16'h0000, 0);
    check(fault && !outValid, "R8 miss on unwritten entry", {30'd0, fault, outValid}, 32'd2);
    repeat (3) begin
      @(negedge clk); #1;
      check(fault && !outValid, "R8 parked after miss", {30'd0, fault, outValid}, 32'd2);
    end
    redirect(expPc[1], 0);
    check(fault && !outValid, "R8 miss on non-target", {30'd0, fault, outValid}, 32'd2);
    redirect(expPc[30], 0);
    check(!fault && !outValid, "R8 hit clears fault", {30'd0, fault, outValid}, 32'd0);
    consume(30, 12);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule